// File: doc/BRIEF.md
# ADC Serial Data Output Shifter

This block is the converter-side logic behind the serial data pin of a successive-approximation ADC. When chip-select falls, it captures a parallel conversion result from a stand-in source and enables its output driver, with the first leading zero already on the line. Each later falling edge of the serial clock moves the line on by one bit. A frame is a fixed run of leading zeros, then the result in straight binary, most significant bit first. After the last falling edge of the frame the driver lets go of the line on its own.

Chip-select and the serial clock are asynchronous to the block. Each one passes through a synchronizer clocked by a faster internal clock, and its edges are detected in that clock domain, so all of the state is synchronous. A readout controller pairs with this model in system tests. Resolution, number of leading zeros and synchronizer depth are parameters: 12, 10 or 8 result bits with four zeros give frames of 16, 14 or 12 clocks.

Top module: `adc_sdo_shifter`

## Requirements
- R1: While reset is held and after it is released, `sdata_oe_o` and `sdata_o` are 0.
- R2: A falling chip-select captures `sample_i` and sets `sdata_oe_o` to 1, with `sdata_o` at 0, the first leading zero.
- R3: Frame bit k is present after k falling edges of the serial clock. Bits 0 to LEAD_ZEROS-1 are 0. Bit LEAD_ZEROS+j is `sample_i[RES_W-1-j]` as captured.
- R4: The falling serial-clock edge numbered LEAD_ZEROS+RES_W (16 with the defaults) drops `sdata_oe_o` to 0.
- R5: When chip-select rises during a frame, `sdata_oe_o` drops and the bit count is cleared. The next frame begins again at the first leading zero.
- R6: Serial-clock edges while chip-select is high, or after the frame has ended with chip-select still low, leave `sdata_oe_o` at 0 until the next falling chip-select.
- R7: Rising serial-clock edges do not change `sdata_o`.
- R8: An edge on an input reaches the outputs on the (SYNC_STAGES+1)-th rising `clk_i` edge that samples the new level, counting that first edge as number one.
- R9: `sdata_o` is 0 whenever `sdata_oe_o` is 0.
- R10: Changes on `sample_i` after the capture do not alter the frame being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sample_i | input | RES_W | Parallel conversion result from the stand-in source |
| sdata_o | output | 1 | Serial data value |
| sdata_oe_o | output | 1 | Output enable for the data line; 0 means high impedance |

## Verification
The bench builds the block with its defaults: 12 result bits, four leading zeros and a two-flop synchronizer, giving 16-clock frames. It holds each serial-clock level for four internal clocks, which is longer than the three-edge input latency. This makes every frame bit observable before the next falling edge and lets the exact latency after chip-select be checked. Frames carrying all ones, all zeros and alternating patterns exercise each bit position. Aborted frames, surplus falling edges, and clock activity with chip-select high cover the release paths. The behavioural reference model also covers coincident edges.

// File: rtl/adc_sdo_pkg.sv
package adc_sdo_pkg;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } fr_state_e;

  function automatic int frame_len(input int res_w, input int lead_zeros);
    return res_w + lead_zeros;
  endfunction

endpackage

// File: rtl/adc_sdo_sync.sv
module adc_sdo_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
  assign rise_o = ~prev_q & sync_q[STAGES-1];

endmodule

// File: rtl/adc_sdo_ctrl.sv
module adc_sdo_ctrl
  import adc_sdo_pkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic sclk_fall_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o
);

  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);

  fr_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             abort;
  logic             step;

  assign abort   = (state_q == FR_SHIFT) & cs_rise_i & ~cs_fall_i;
  assign step    = (state_q == FR_SHIFT) & sclk_fall_i & ~cs_rise_i & ~cs_fall_i;
  assign load_o  = cs_fall_i;
  assign shift_o = step;
  assign active_o = (state_q == FR_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
    end else if (cs_fall_i) begin
      state_q <= FR_SHIFT;
      cnt_q   <= '0;
    end else if (abort) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
    end else if (step) begin
      if (cnt_q == LAST_CNT) begin
        state_q <= FR_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_sdo_shreg.sv
module adc_sdo_shreg #(
  parameter int RES_W      = 12,
  parameter int LEAD_ZEROS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             bit_o
);

  localparam int FRAME_W = RES_W + LEAD_ZEROS;

  logic [FRAME_W-1:0] sh_q;

  // leading zeros come from zero extension of the captured result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= FRAME_W'(sample_i);
    else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[FRAME_W-1];

endmodule

// File: rtl/adc_sdo_shifter.sv
module adc_sdo_shifter
  import adc_sdo_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LEAD_ZEROS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdata_o,
  output logic             sdata_oe_o
);

  localparam int FRAME_LEN = frame_len(RES_W, LEAD_ZEROS);
  localparam int CS_IDX    = 0;
  localparam int SCLK_IDX  = 1;

  logic [1:0] raw_in;
  logic [1:0] fall_v;
  logic [1:0] rise_v;
  logic       cs_fall, cs_rise, sclk_fall;
  logic       load, shift, active, cur_bit;

  assign raw_in = {sclk_i, cs_n_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    adc_sdo_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_in[g]),
      .fall_o (fall_v[g]),
      .rise_o (rise_v[g])
    );
  end

  assign cs_fall   = fall_v[CS_IDX];
  assign cs_rise   = rise_v[CS_IDX];
  assign sclk_fall = fall_v[SCLK_IDX];

  adc_sdo_ctrl #(
    .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .load_o     (load),
    .shift_o    (shift),
    .active_o   (active)
  );

  adc_sdo_shreg #(
    .RES_W     (RES_W),
    .LEAD_ZEROS(LEAD_ZEROS)
  ) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .sample_i(sample_i),
    .bit_o   (cur_bit)
  );

  assign sdata_oe_o = active;
  assign sdata_o    = active & cur_bit;

endmodule

// File: rtl/adc_sdo_chk.sv
module adc_sdo_chk #(
  parameter int FRAME_LEN = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] fall_v,
  input logic [1:0] rise_v,
  input logic       sdata_o,
  input logic       sdata_oe_o
);

  localparam int CW = $clog2(FRAME_LEN + 1) + 1;

  logic [CW-1:0] falls_q;

  // independent count of falling clock edges inside the enabled window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  falls_q <= '0;
    else if (fall_v[0])                           falls_q <= '0;
    else if (!sdata_oe_o)                         falls_q <= '0;
    else if (fall_v[1] && !rise_v[0])             falls_q <= falls_q + 1'b1;
  end

  // R2
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> !sdata_o);

  // R6
  enable_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(fall_v[0]));

  // R5
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && rise_v[0] && !fall_v[0]) |=> !sdata_oe_o);

  // R3
  hold_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && !fall_v[1] && !rise_v[0] && !fall_v[0]) |=> (sdata_oe_o && $stable(sdata_o)));

  // R7
  rise_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && rise_v[1] && !fall_v[1] && !rise_v[0]) |=> $stable(sdata_o));

  // R4
  frame_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (falls_q < CW'(FRAME_LEN)));

  // R9
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);

endmodule

bind adc_sdo_shifter adc_sdo_chk #(
  .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fall_v    (fall_v),
  .rise_v    (rise_v),
  .sdata_o   (sdata_o),
  .sdata_oe_o(sdata_oe_o)
);

// File: tb/tb_adc_sdo_shifter.sv
module tb_adc_sdo_shifter;

  localparam int RES_W = 12;
  localparam int LZ    = 4;
  localparam int S     = 2;
  localparam int N     = RES_W + LZ;
  localparam int H     = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cs_n_i = 1'b1;
  logic             sclk_i = 1'b1;
  logic [RES_W-1:0] sample_i = '0;
  logic             sdata_o, sdata_oe_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  adc_sdo_shifter #(.RES_W(RES_W), .LEAD_ZEROS(LZ), .SYNC_STAGES(S)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
    .sample_i(sample_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  // behavioural reference: input history queues, frame position counter
  bit               cq[$];
  bit               sq[$];
  bit               m_act;
  int               m_pos;
  logic [RES_W-1:0] m_word;
  bit               exp_oe, exp_d;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cq.delete(); sq.delete();
      for (int i = 0; i < S + 2; i++) begin cq.push_back(1'b1); sq.push_back(1'b1); end
      m_act = 0; m_pos = 0; m_word = '0;
    end else begin
      bit cf, cr, sf;
      cq.push_back(cs_n_i); sq.push_back(sclk_i);
      void'(cq.pop_front()); void'(sq.pop_front());
      cf = cq[0] && !cq[1];
      cr = !cq[0] && cq[1];
      sf = sq[0] && !sq[1];
      if (cf) begin
        m_act = 1; m_pos = 0; m_word = sample_i;
      end else if (m_act && cr) begin
        m_act = 0; m_pos = 0;
      end else if (m_act && sf) begin
        m_pos++;
        if (m_pos == N) begin m_act = 0; m_pos = 0; end
      end
    end
    exp_oe = m_act;
    exp_d  = m_act && (m_pos >= LZ) && m_word[RES_W-1-(m_pos-LZ)];
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    n_cmp++;
    if (sdata_oe_o !== exp_oe || sdata_o !== exp_d) begin
      n_bad++;
      $display("FAIL %s cycle model: actual oe=%b d=%b expected oe=%b d=%b at %0t",
               cur_req, sdata_oe_o, sdata_o, exp_oe, exp_d, $time);
    end
  end

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // one frame: nfalls falling serial clock edges, then chip-select released
  task automatic run_frame(input logic [RES_W-1:0] val, input int nfalls);
    logic [N-1:0] got;
    got = '0;
    sample_i = val;
    @(negedge clk_i);
    cs_n_i = 1'b0;
    wait_n(S);
    check("R8 oe before latency", int'(sdata_oe_o), 0);
    wait_n(1);
    check("R2 oe after cs fall", int'(sdata_oe_o), 1);
    check("R2 first zero", int'(sdata_o), 0);
    got[N-1] = sdata_o;
    sample_i = ~val;  // R10
    wait_n(H);
    for (int i = 1; i <= nfalls; i++) begin
      sclk_i = 1'b0;
      wait_n(S + 1);
      if (i < N) begin
        got[N-1-i] = sdata_o;
        check("R3 oe mid frame", int'(sdata_oe_o), 1);
      end else begin
        check(i == N ? "R4 release" : "R6 extra fall", int'(sdata_oe_o), 0);
        check("R9 idle data", int'(sdata_o), 0);
      end
      wait_n(H - S - 1);
      sclk_i = 1'b1;
      wait_n(S + 1);
      if (i < N) check("R7 rise holds bit", int'(sdata_o), int'(got[N-1-i]));
      wait_n(H - S - 1);
    end
    if (nfalls >= N) check("R3 R10 frame word", int'(got), int'({{LZ{1'b0}}, val}));
    cs_n_i = 1'b1;
    if (nfalls < N) begin
      wait_n(S);
      check("R5 oe before abort latency", int'(sdata_oe_o), 1);
      wait_n(1);
      check("R5 abort release", int'(sdata_oe_o), 0);
    end
    wait_n(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL %s watchdog: actual=timeout expected=finish", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    check("R1 oe in reset", int'(sdata_oe_o), 0);
    check("R1 data in reset", int'(sdata_o), 0);
    rst_ni = 1'b1;
    wait_n(3);
    check("R1 oe after reset", int'(sdata_oe_o), 0);

    cur_req = "R3";
    run_frame(12'hA5C, N);
    run_frame(12'hFFF, N);
    run_frame(12'h000, N);
    run_frame(12'h801, N);

    cur_req = "R5";
    run_frame(12'h3C7, 7);
    run_frame(12'hE1B, N);

    cur_req = "R6";
    run_frame(12'h5A5, N + 4);
    for (int i = 0; i < 5; i++) begin
      sclk_i = 1'b0; wait_n(H);
      sclk_i = 1'b1; wait_n(H);
      check("R6 idle clocks", int'(sdata_oe_o), 0);
    end

    cur_req = "R8";
    run_frame(12'h96E, N);
    wait_n(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule